// File: doc/BRIEF.md
# Bus Port Quiesce Handshake Controller

This block takes one bus master port out of traffic before a power sequencer switches that port off. When the sequencer issues a halt command, the block first checks whether the port already reports idle. If it does, the block finishes at once and never raises a halt request. Otherwise it raises the halt request and waits for the port's acknowledge. It looks at the acknowledge only on millisecond ticks, and it gives up after a parameterised number of ticks.

Once the wait is over, whether by acknowledge or by timeout, the block samples the port's idle status one more time. It then drops the halt request and sends the sequencer a one-cycle completion pulse, with a failure flag that is valid in the same cycle. The port is expected to stay halted until it is reset, so dropping the request does not release it.

Top module: `port_quiesce_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `halt_req`, `done` and `failed` are all 0.
- R2: If `halt_cmd` is sampled while the controller is free and `port_idle` is 1, `done` is 1 in the next cycle with `failed` = 0, and `halt_req` stays 0 throughout.
- R3: If `halt_cmd` is sampled while the controller is free and `port_idle` is 0, `halt_req` is 1 from the next cycle onward, and it stays 1 until the completion cycle.
- R4: While waiting, `halt_ack` is looked at only in cycles where `ms_tick` is 1. An acknowledge without a tick does not end the wait.
- R5: An edge with `ms_tick` = 1 and `halt_ack` = 1 ends the wait. `done` is then 1 two cycles after that tick cycle, counting the tick cycle as cycle 0.
- R6: If no acknowledge has been seen, the wait ends on the TIMEOUT_MS-th tick. Before that tick there is no `done`, and `halt_req` stays 1.
- R7: Idle is re-sampled on the edge after the one that ended the wait. `failed` = 1 exactly when `port_idle` was 0 on that edge, whether the wait ended by acknowledge or by timeout.
- R8: `halt_req` is 0 in the completion cycle, and it stays 0 until the next accepted command.
- R9: `done` is high for exactly one cycle per command, and `failed` is never 1 unless `done` is 1.
- R10: A `halt_cmd` that arrives while a handshake is in progress is ignored. It yields no extra `done` and no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_cmd | input | 1 | One-cycle request from the sequencer to quiesce the port |
| port_idle | input | 1 | Port reports no outstanding transactions |
| halt_ack | input | 1 | Port acknowledges the halt request |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| halt_req | output | 1 | Halt request to the port |
| done | output | 1 | One-cycle completion pulse |
| failed | output | 1 | Port was not idle at the final check; valid with `done` |

## Verification
The hardest situation to reach is a change of idle status at the exact edge where the block re-samples it. In that case the outcome depends on the value one cycle after the wait ends, not on the value during the wait. The stimulus ends the wait with a tick-aligned acknowledge and then flips `port_idle` on the very next negative edge, in both directions. A timeout with a port that recovers is also covered. Separate cases hold `halt_ack` high without ticks, and fire a second command in the middle of a handshake.

// File: rtl/qh_pkg.sv
// Package: shared state encoding for the port quiesce controller.
// Assumes: a three-phase sequence (free, waiting for ack, final idle check).
package qh_pkg;
    typedef enum logic [1:0] {
        QH_FREE  = 2'd0,
        QH_WAIT  = 2'd1,
        QH_CHECK = 2'd2
    } qh_state_e;
endpackage

// File: rtl/qh_tick_timer.sv
// Module: qh_tick_timer
// Counts millisecond ticks during the acknowledge wait and flags the tick
// that would be the last one allowed.
// Assumes: clear is held whenever no wait is in progress; TIMEOUT_MS >= 1.
module qh_tick_timer #(
    parameter int TIMEOUT_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic last_tick
);
    localparam int CW = (TIMEOUT_MS < 2) ? 1 : $clog2(TIMEOUT_MS);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_MS - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: count elapsed ticks, restarting whenever the wait is not active.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (count_en && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: the current count equals the final allowed tick index.
    always_comb begin
        last_tick = (cnt_q == LAST);
    end
endmodule

// File: rtl/qh_seq_fsm.sv
// Module: qh_seq_fsm
// Sequences the handshake: skip-if-idle, raise request, wait for ack on
// ticks bounded by the timer, re-check idle, drop request, report.
// Assumes: halt_cmd is a single-cycle pulse; ms_tick is a single-cycle pulse.
module qh_seq_fsm
    import qh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_cmd,
    input  logic      port_idle,
    input  logic      halt_ack,
    input  logic      ms_tick,
    input  logic      last_tick,
    output qh_state_e state,
    output logic      halt_req,
    output logic      done,
    output logic      failed
);
    qh_state_e st_q;
    logic      req_q;
    logic      done_q;
    logic      fail_q;
    logic      wait_over;

    // Purpose: the wait ends on a tick that sees the ack or exhausts the budget.
    always_comb begin
        wait_over = ms_tick && (halt_ack || last_tick);
    end

    // Purpose: state, request and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= QH_FREE;
            req_q  <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            unique case (st_q)
                QH_FREE: begin
                    if (halt_cmd) begin
                        if (port_idle) begin
                            done_q <= 1'b1;
                        end else begin
                            req_q <= 1'b1;
                            st_q  <= QH_WAIT;
                        end
                    end
                end
                QH_WAIT: begin
                    if (wait_over) begin
                        st_q <= QH_CHECK;
                    end
                end
                QH_CHECK: begin
                    done_q <= 1'b1;
                    fail_q <= !port_idle;
                    req_q  <= 1'b0;
                    st_q   <= QH_FREE;
                end
                default: begin
                    st_q  <= QH_FREE;
                    req_q <= 1'b0;
                end
            endcase
        end
    end

    // Purpose: drive outputs from registers only.
    always_comb begin
        state    = st_q;
        halt_req = req_q;
        done     = done_q;
        failed   = fail_q;
    end
endmodule

// File: rtl/port_quiesce_ctrl.sv
// Module: port_quiesce_ctrl
// Top level: quiesces one bus master port with a bounded halt handshake.
// Assumes: all inputs are synchronous to clk; TIMEOUT_MS counts ms_tick pulses.
module port_quiesce_ctrl
    import qh_pkg::*;
#(
    parameter int TIMEOUT_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_cmd,
    input  logic port_idle,
    input  logic halt_ack,
    input  logic ms_tick,
    output logic halt_req,
    output logic done,
    output logic failed
);
    qh_state_e st_w;
    logic      last_tick_w;
    logic      waiting_w;
    logic      cnt_en_w;

    // Purpose: enable the timer only on ack-less ticks during the wait.
    always_comb begin
        waiting_w = (st_w == QH_WAIT);
        cnt_en_w  = waiting_w && ms_tick && !halt_ack;
    end

    qh_tick_timer #(
        .TIMEOUT_MS(TIMEOUT_MS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!waiting_w),
        .count_en (cnt_en_w),
        .last_tick(last_tick_w)
    );

    qh_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_cmd (halt_cmd),
        .port_idle(port_idle),
        .halt_ack (halt_ack),
        .ms_tick  (ms_tick),
        .last_tick(last_tick_w),
        .state    (st_w),
        .halt_req (halt_req),
        .done     (done),
        .failed   (failed)
    );
endmodule

// File: rtl/qh_checker.sv
// Module: qh_checker
// Temporal properties of the quiesce controller, bound to its top level.
// Assumes: sampled on the rising edge, disabled during reset.
module qh_checker
    import qh_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      halt_cmd,
    input logic      port_idle,
    input logic      halt_ack,
    input logic      ms_tick,
    input logic      halt_req,
    input logic      done,
    input logic      failed,
    input qh_state_e st
);
    p_skip_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == QH_FREE && halt_cmd && port_idle) |=> (done && !failed && !halt_req));

    p_req_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> ($past(halt_cmd) && !$past(port_idle)));

    p_tick_gated_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == QH_WAIT && !ms_tick) |=> (st == QH_WAIT));

    p_ack_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == QH_WAIT && ms_tick && halt_ack) |=> (st == QH_CHECK));

    p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == QH_WAIT) |-> (halt_req && !done));

    p_final_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == QH_CHECK) |=> (done && (failed == !$past(port_idle))));

    p_req_low_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !halt_req);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fail_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> done);

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == QH_WAIT && halt_cmd && !ms_tick) |=> (st == QH_WAIT));
endmodule

bind port_quiesce_ctrl qh_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_cmd (halt_cmd),
    .port_idle(port_idle),
    .halt_ack (halt_ack),
    .ms_tick  (ms_tick),
    .halt_req (halt_req),
    .done     (done),
    .failed   (failed),
    .st       (st_w)
);

// File: tb/port_quiesce_ctrl_tb_top.sv
module port_quiesce_ctrl_tb_top;
    localparam int TMO = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_cmd = 1'b0;
    logic port_idle = 1'b0;
    logic halt_ack = 1'b0;
    logic ms_tick = 1'b0;
    logic halt_req;
    logic done;
    logic failed;

    int n_checks = 0;
    int n_errors = 0;
    bit exp_q[$];
    bit finished = 1'b0;

    always #5 clk = ~clk;

    port_quiesce_ctrl #(.TIMEOUT_MS(TMO)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_cmd (halt_cmd),
        .port_idle(port_idle),
        .halt_ack (halt_ack),
        .ms_tick  (ms_tick),
        .halt_req (halt_req),
        .done     (done),
        .failed   (failed)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops an expected failure flag for every completion pulse.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (failed && !done) chk(1'b0, "R9 failed without done", 1, 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9/R10 unexpected done", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(failed == e, "R7 failed flag", int'(failed), int'(e));
                end
            end
        end
    end

    task automatic pulse_cmd();
        halt_cmd = 1'b1;
        @(negedge clk);
        halt_cmd = 1'b0;
    endtask

    task automatic pulse_tick();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R1: reset state
        idle_cycles(3);
        chk(!halt_req && !done && !failed, "R1 reset outputs", int'({halt_req, done, failed}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!halt_req && !done && !failed, "R1 after reset", int'({halt_req, done, failed}), 0);

        // R2: already idle -> immediate done, no request
        port_idle = 1'b1;
        exp_q.push_back(1'b0);
        pulse_cmd();
        chk(done == 1'b1, "R2 done next cycle", int'(done), 1);
        chk(halt_req == 1'b0, "R2 no request", int'(halt_req), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 single pulse", int'(done), 0);

        // R3/R4/R5/R8: ack without tick ignored; ack on tick ends wait
        port_idle = 1'b0;
        pulse_cmd();
        chk(halt_req == 1'b1, "R3 request raised", int'(halt_req), 1);
        halt_ack = 1'b1;
        idle_cycles(5);
        chk(halt_req == 1'b1 && !done, "R4 ack w/o tick ignored", int'(halt_req), 1);
        port_idle = 1'b1;
        exp_q.push_back(1'b0);
        pulse_tick();
        chk(!done && halt_req, "R5 check cycle", int'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R5 done after ack tick", int'(done), 1);
        chk(halt_req == 1'b0, "R8 request dropped", int'(halt_req), 0);
        halt_ack = 1'b0;
        idle_cycles(3);
        chk(halt_req == 1'b0, "R8 request stays low", int'(halt_req), 0);

        // R6/R7: timeout with port still busy -> failure
        port_idle = 1'b0;
        pulse_cmd();
        for (int i = 0; i < TMO - 1; i++) begin
            pulse_tick();
            @(negedge clk);
        end
        chk(halt_req == 1'b1 && !done, "R6 still waiting before last tick", int'(halt_req), 1);
        exp_q.push_back(1'b1);
        pulse_tick();
        @(negedge clk);
        chk(done && failed && !halt_req, "R6 timeout completion", int'({done, failed, halt_req}), 6);
        idle_cycles(2);

        // R6/R7: timeout but port recovered -> success
        pulse_cmd();
        port_idle = 1'b1;
        for (int i = 0; i < TMO - 1; i++) begin
            pulse_tick();
            @(negedge clk);
        end
        exp_q.push_back(1'b0);
        pulse_tick();
        @(negedge clk);
        chk(done && !failed, "R7 timeout idle success", int'({done, failed}), 2);
        idle_cycles(2);

        // R7: busy during ack tick, idle exactly at re-sample -> success
        port_idle = 1'b0;
        pulse_cmd();
        halt_ack = 1'b1;
        exp_q.push_back(1'b0);
        pulse_tick();
        port_idle = 1'b1;
        halt_ack = 1'b0;
        @(negedge clk);
        chk(done && !failed, "R7 late idle success", int'({done, failed}), 2);
        idle_cycles(2);

        // R7: idle during ack tick, busy at re-sample -> failure
        port_idle = 1'b0;
        pulse_cmd();
        port_idle = 1'b1;
        halt_ack = 1'b1;
        exp_q.push_back(1'b1);
        pulse_tick();
        port_idle = 1'b0;
        halt_ack = 1'b0;
        @(negedge clk);
        chk(done && failed, "R7 late busy failure", int'({done, failed}), 3);
        idle_cycles(2);

        // R10: commands during wait and during check are ignored
        pulse_cmd();
        port_idle = 1'b1;
        idle_cycles(2);
        pulse_cmd();
        chk(halt_req == 1'b1 && !done, "R10 cmd in wait ignored", int'(done), 0);
        halt_ack = 1'b1;
        exp_q.push_back(1'b0);
        pulse_tick();
        halt_ack = 1'b0;
        halt_cmd = 1'b1;
        @(negedge clk);
        halt_cmd = 1'b0;
        chk(done && !halt_req, "R10 single completion", int'(done), 1);
        idle_cycles(6);
        chk(halt_req == 1'b0 && !done, "R10 no new request", int'(halt_req), 0);

        chk(exp_q.size() == 0, "R9 all completions seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule